// File: doc/BRIEF.md
# Byte/Word Configurable ROM Read Port

This block is a clocked model of the read side of a one-time-programmable ROM. The ROM is organised either as 16-bit words or as 8-bit bytes. A single mode input picks the organisation. One pin has two jobs: in word mode it carries data bit 15 out, and in byte mode it is an input that picks which half of the addressed word appears on the low byte lane. Two active-low controls gate the outputs. The chip select puts the part into standby. The output gate turns the data drivers on or off while the part is selected.

A separate identification flag stands in for the overvoltage detect on address line 9. While that flag is set, the array is bypassed and a fixed signature byte is returned, chosen by address bit 0. Instead of real tri-state pins, the block drives three lane enables: the low byte, the middle seven bits, and the dual-purpose top bit. Data bits on a disabled lane read as zero. The storage array is filled through a simple write port before any reads begin.

Read results appear a fixed, parameterised number of clock edges after the inputs are sampled. After the part returns from byte mode to word mode, the upper lanes stay disabled for an extra, parameterised recovery window.

Top module: `cfg_rom_port`

## Requirements
- R1: While rst_n is low, all three lane enables are low and dq_out is zero.
- R2: Timing of a normal word read. The inputs are ce_n=0, oe_n=0, word_mode=1 and sig_hv=0, first sampled at clock edge k. After edge k+LAT-1 (LAT defaults to 2), dq_out[15:0] equals the stored word and all three lane enables are high. Before that edge, the output still shows the previous access.
- R3: Standby. With ce_n=1, all three lane enables are low and dq_out is zero, whatever oe_n is.
- R4: Output disable. With ce_n=0 and oe_n=1, all three lane enables are low.
- R5: Byte-mode data. With word_mode=0 and the part enabled, lsb_sel=0 puts bits 7..0 of the addressed word on dq_out[7:0], and lsb_sel=1 puts bits 15..8 there.
- R6: Upper lanes in byte mode. With word_mode=0, lane_mid_en and lane_msb_en are low and dq_out[15:8] is zero.
- R7: Signature readout. With sig_hv=1 and the part enabled, dq_out[7:0] is 8'h20 when addr[0]=0 and 8'hB2 when addr[0]=1. The array is ignored, and so is lsb_sel. In word mode, dq_out[15:8] is zero with its lanes enabled. A signature access must keep every address bit other than bits 0 and 9 at zero.
- R8: Recovery after byte mode. word_mode rises before edge k and stays high. The low lane shows word data after edge k+LAT-1. The upper lanes stay disabled until after edge k+WAKE+LAT-1, and are enabled from then on (WAKE defaults to 3).
- R9: Every data bit on a disabled lane reads as zero.
- R10: Only the low ARRAY_AW bits of addr (default 10) select a stored word. Higher address bits alias.
- R11: With ld_we=1 at a rising edge, ld_data is written to word ld_addr. Later reads of that word return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip select; high means standby |
| oe_n | input | 1 | Active-low output gate |
| word_mode | input | 1 | 1 = 16-bit organisation, 0 = 8-bit organisation |
| lsb_sel | input | 1 | Byte-half select, used only in byte mode |
| sig_hv | input | 1 | Identification flag (overvoltage on address line 9) |
| ld_we | input | 1 | Array load strobe |
| ld_addr | input | ARRAY_AW | Array load address |
| ld_data | input | 16 | Array load data |
| dq_out | output | 16 | Data out; bit 15 is the dual-purpose pin |
| lane_lo_en | output | 1 | Drive enable for dq_out[7:0] |
| lane_mid_en | output | 1 | Drive enable for dq_out[14:8] |
| lane_msb_en | output | 1 | Drive enable for dq_out[15] |

## Verification
The recovery counter and the captured control word are the only hidden state. A recovery counter stuck at zero shows up as upper lanes that switch on in the first cycle after word mode returns. A counter that never reaches zero leaves those lanes off for good. Either fault is visible within WAKE+LAT cycles of the mode change. A fault in the pipeline or the array read appears as wrong data, or as a lane change that comes one cycle early or late, exactly LAT edges after the affected access.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] SIG_CODE_LO = 8'h20;
   localparam logic [BYTE_W-1:0] SIG_CODE_HI = 8'hB2;

   // control captured alongside the synchronous array read
   typedef struct packed {
      logic en;
      logic sig;
      logic wide;
      logic upper_ok;
      logic sel;
      logic a0;
   } rd_ctrl_t;

   // formatted port state
   typedef struct packed {
      logic [WORD_W-1:0] dq;
      logic              lo;
      logic              mid;
      logic              msb;
   } rd_out_t;
endpackage

// File: rtl/cfg_rom_store.sv
module cfg_rom_store #(
   parameter int AW = 10,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
   end
endmodule

// File: rtl/cfg_rom_ctl.sv
module cfg_rom_ctl
   import cfg_rom_pkg::*;
#(
   parameter int WAKE = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ce_n,
   input  logic     oe_n,
   input  logic     word_mode,
   input  logic     lsb_sel,
   input  logic     sig_hv,
   input  logic     a0,
   output rd_ctrl_t ctrl_q
);
   localparam int CW = $clog2(WAKE + 1);

   logic [CW-1:0] wake_cnt;
   rd_ctrl_t      ctrl_d;

   // recovery window: reloaded while in byte mode, drains in word mode
   always_ff @(posedge clk) begin
      if (!rst_n)          wake_cnt <= '0;
      else if (!word_mode) wake_cnt <= CW'(WAKE);
      else if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
   end

   always_comb begin
      ctrl_d.en       = ~ce_n & ~oe_n;
      ctrl_d.sig      = sig_hv;
      ctrl_d.wide     = word_mode;
      ctrl_d.upper_ok = (wake_cnt == '0);
      ctrl_d.sel      = lsb_sel;
      ctrl_d.a0       = a0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end
endmodule

// File: rtl/cfg_rom_fmt.sv
module cfg_rom_fmt
   import cfg_rom_pkg::*;
(
   input  rd_ctrl_t          ctrl,
   input  logic [WORD_W-1:0] word,
   output rd_out_t           out
);
   logic [BYTE_W-1:0] low_b;
   logic [BYTE_W-1:0] up_b;
   logic              up_on;

   always_comb begin
      up_on = ctrl.en & ctrl.wide & ctrl.upper_ok;
      if (ctrl.sig) begin
         low_b = ctrl.a0 ? SIG_CODE_HI : SIG_CODE_LO;
         up_b  = '0;
      end else begin
         up_b  = word[WORD_W-1:BYTE_W];
         if (ctrl.wide || !ctrl.sel) low_b = word[BYTE_W-1:0];
         else                        low_b = word[WORD_W-1:BYTE_W];
      end
      out.lo  = ctrl.en;
      out.mid = up_on;
      out.msb = up_on;
      out.dq[BYTE_W-1:0]        = ctrl.en ? low_b : '0;
      out.dq[WORD_W-2:BYTE_W]   = up_on ? up_b[BYTE_W-2:0] : '0;
      out.dq[WORD_W-1]          = up_on & up_b[BYTE_W-1];
   end
endmodule

// File: rtl/cfg_rom_pipe.sv
module cfg_rom_pipe
   import cfg_rom_pkg::*;
#(
   parameter int DEPTH = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  rd_out_t d,
   output rd_out_t q
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign q = d;
      end else begin : g_regs
         rd_out_t stg [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/cfg_rom_port.sv
module cfg_rom_port
   import cfg_rom_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int ARRAY_AW = 10,
   parameter int LAT      = 2,
   parameter int WAKE     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                ce_n,
   input  logic                oe_n,
   input  logic                word_mode,
   input  logic                lsb_sel,
   input  logic                sig_hv,
   input  logic                ld_we,
   input  logic [ARRAY_AW-1:0] ld_addr,
   input  logic [WORD_W-1:0]   ld_data,
   output logic [WORD_W-1:0]   dq_out,
   output logic                lane_lo_en,
   output logic                lane_mid_en,
   output logic                lane_msb_en
);
   localparam int PIPE_DEPTH = LAT - 1;

   if (LAT < 1)               begin : g_bad_lat  $error("LAT must be at least 1"); end
   if (WAKE < 1)              begin : g_bad_wake $error("WAKE must be at least 1"); end
   if (ADDR_W < 10)           begin : g_bad_aw   $error("ADDR_W must cover bit 9"); end
   if (ARRAY_AW > ADDR_W || ARRAY_AW < 1) begin : g_bad_arr $error("ARRAY_AW out of range"); end

   if (ARRAY_AW < ADDR_W) begin : g_alias
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr[ADDR_W-1:ARRAY_AW];
   end

   logic [WORD_W-1:0] rd_word;
   rd_ctrl_t          ctrl_q;
   rd_out_t           fmt_o;
   rd_out_t           pipe_o;

   cfg_rom_store #(.AW(ARRAY_AW), .DW(WORD_W)) u_store (
      .clk   (clk),
      .we    (ld_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (addr[ARRAY_AW-1:0]),
      .rdata (rd_word)
   );

   cfg_rom_ctl #(.WAKE(WAKE)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .word_mode (word_mode),
      .lsb_sel   (lsb_sel),
      .sig_hv    (sig_hv),
      .a0        (addr[0]),
      .ctrl_q    (ctrl_q)
   );

   cfg_rom_fmt u_fmt (
      .ctrl (ctrl_q),
      .word (rd_word),
      .out  (fmt_o)
   );

   cfg_rom_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fmt_o),
      .q     (pipe_o)
   );

   assign dq_out      = pipe_o.dq;
   assign lane_lo_en  = pipe_o.lo;
   assign lane_mid_en = pipe_o.mid;
   assign lane_msb_en = pipe_o.msb;
endmodule

// File: rtl/cfg_rom_port_chk.sv
module cfg_rom_port_chk #(
   parameter int ADDR_W = 19,
   parameter int LAT    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              ce_n,
   input logic              oe_n,
   input logic              word_mode,
   input logic              sig_hv,
   input logic [15:0]       dq_out,
   input logic              lane_lo_en,
   input logic              lane_mid_en,
   input logic              lane_msb_en
);
   localparam int CW = $clog2(LAT + 1);

   logic [CW-1:0] quiet_run;
   logic [CW-1:0] byte_run;
   logic [ADDR_W-1:0] sig_mask;

   always_comb begin
      sig_mask    = '1;
      sig_mask[0] = 1'b0;
      sig_mask[9] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_run <= '0;
         byte_run  <= '0;
      end else begin
         if (!(ce_n | oe_n))          quiet_run <= '0;
         else if (quiet_run != CW'(LAT)) quiet_run <= quiet_run + 1'b1;
         if (word_mode)               byte_run <= '0;
         else if (byte_run != CW'(LAT))  byte_run <= byte_run + 1'b1;
      end
   end

   // R3 and R4: a long enough deselected or gated run leaves all lanes off
   p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_run == CW'(LAT)) |-> !(lane_lo_en | lane_mid_en | lane_msb_en));

   // R6: settled byte mode keeps the upper lanes off
   p_byte_upper_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_run == CW'(LAT)) |-> !(lane_mid_en | lane_msb_en));

   // R8: upper lanes switch together and never without the low lane
   p_upper_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_mid_en == lane_msb_en) && (!lane_mid_en || lane_lo_en));

   // R9: disabled lanes read as zero
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_lo_en -> dq_out[7:0] == 8'h00) &&
      (!lane_mid_en -> dq_out[14:8] == 7'h00) &&
      (!lane_msb_en -> !dq_out[15]));

   // R7: signature access only with clean address bits
   p_sig_addr_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_hv && !ce_n && !oe_n) |-> ((addr & sig_mask) == '0));

   // R1: outputs idle in the first cycle after reset
   p_reset_idle_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !(lane_lo_en | lane_mid_en | lane_msb_en));
endmodule

bind cfg_rom_port cfg_rom_port_chk #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr        (addr),
   .ce_n        (ce_n),
   .oe_n        (oe_n),
   .word_mode   (word_mode),
   .sig_hv      (sig_hv),
   .dq_out      (dq_out),
   .lane_lo_en  (lane_lo_en),
   .lane_mid_en (lane_mid_en),
   .lane_msb_en (lane_msb_en)
);

// File: tb/cfg_rom_port_test.sv
module cfg_rom_port_test;
   localparam int ADDR_W = 19;
   localparam int AAW    = 10;
   localparam int LAT    = 2;
   localparam int WAKE   = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] addr;
   logic              ce_n, oe_n, word_mode, lsb_sel, sig_hv;
   logic              ld_we;
   logic [AAW-1:0]    ld_addr;
   logic [15:0]       ld_data;
   logic [15:0]       dq_out;
   logic              lane_lo_en, lane_mid_en, lane_msb_en;

   logic [15:0] shadow [1 << AAW];
   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   cfg_rom_port #(.ADDR_W(ADDR_W), .ARRAY_AW(AAW), .LAT(LAT), .WAKE(WAKE)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .word_mode(word_mode), .lsb_sel(lsb_sel), .sig_hv(sig_hv),
      .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
      .dq_out(dq_out), .lane_lo_en(lane_lo_en), .lane_mid_en(lane_mid_en),
      .lane_msb_en(lane_msb_en)
   );

   // expected {dq, lo, mid, msb}
   function automatic logic [18:0] expect_out(logic cs_n, logic g_n, logic wide, logic sel,
                                              logic sig, logic [ADDR_W-1:0] a, logic up_ok);
      logic [15:0] w;
      logic [7:0]  lo_b, up_b;
      logic        on, up_on;
      w     = shadow[a[AAW-1:0]];
      on    = !cs_n && !g_n;
      up_on = on && wide && up_ok;
      if (sig) begin
         lo_b = a[0] ? 8'hB2 : 8'h20;
         up_b = 8'h00;
      end else begin
         up_b = w[15:8];
         lo_b = (!wide && sel) ? w[15:8] : w[7:0];
      end
      return {up_on ? up_b : 8'h00, on ? lo_b : 8'h00, on, up_on, up_on};
   endfunction

   task automatic check(string req, logic [18:0] exp);
      logic [18:0] got;
      got = {dq_out, lane_lo_en, lane_mid_en, lane_msb_en};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got dq=%h lanes=%b expected dq=%h lanes=%b",
                  req, got[18:3], got[2:0], exp[18:3], exp[2:0]);
      end
   endtask

   task automatic drive(logic cs_n, logic g_n, logic wide, logic sel, logic sig,
                        logic [ADDR_W-1:0] a);
      @(negedge clk);
      ce_n = cs_n; oe_n = g_n; word_mode = wide; lsb_sel = sel; sig_hv = sig; addr = a;
   endtask

   task automatic settle();
      repeat (LAT) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic access(string req, logic cs_n, logic g_n, logic wide, logic sel,
                         logic sig, logic [ADDR_W-1:0] a);
      drive(cs_n, g_n, wide, sel, sig, a);
      settle();
      check(req, expect_out(cs_n, g_n, wide, sel, sig, a, 1'b1));
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n = 0; ce_n = 0; oe_n = 0; word_mode = 1; lsb_sel = 0; sig_hv = 0;
      addr = '0; ld_we = 0; ld_addr = '0; ld_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 19'h0);
      ce_n = 1; oe_n = 1;
      rst_n = 1;

      // R11: fill the array
      for (int i = 0; i < (1 << AAW); i++) begin
         @(negedge clk);
         ld_we = 1; ld_addr = AAW'(i); ld_data = 16'($urandom);
         shadow[i] = ld_data;
      end
      @(negedge clk);
      ld_we = 0;
      repeat (WAKE + 2) @(posedge clk);

      // R2: directed word read and latency edge
      access("R2", 0, 0, 1, 0, 0, 19'h00011);
      drive(0, 0, 1, 0, 0, 19'h00022);
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      check("R2 latency old", expect_out(0, 0, 1, 0, 0, 19'h00011, 1));
      @(posedge clk);
      @(negedge clk);
      check("R2 latency new", expect_out(0, 0, 1, 0, 0, 19'h00022, 1));

      // R3 R9 standby with gate active, R4 output disable
      access("R3 R9 standby", 1, 0, 1, 0, 0, 19'h00033);
      access("R4 disable", 0, 1, 1, 0, 0, 19'h00033);

      // R10: aliasing of high address bits
      access("R10 alias", 0, 0, 1, 0, 0, {9'h1AB, 10'h005});

      // R11: rewrite a word and read it back
      @(negedge clk);
      ld_we = 1; ld_addr = 10'd7; ld_data = 16'hA55A; shadow[7] = 16'hA55A;
      @(negedge clk);
      ld_we = 0;
      access("R11 rewrite", 0, 0, 1, 0, 0, 19'h00007);

      // R7: signature codes
      access("R7 sig a0=0", 0, 0, 1, 0, 1, 19'h00000);
      access("R7 sig a0=1", 0, 0, 1, 0, 1, 19'h00001);
      access("R7 sig byte", 0, 0, 0, 1, 1, 19'h00001);
      access("R7 sig byte a0=0", 0, 0, 0, 1, 1, 19'h00000);

      // R5 R6: directed byte halves
      access("R5 R6 low half", 0, 0, 0, 0, 0, 19'h00007);
      access("R5 R6 high half", 0, 0, 0, 1, 0, 19'h00007);

      // R8: recovery after byte mode
      drive(0, 0, 1, 0, 0, 19'h00007);
      for (int n = 1; n <= WAKE + LAT; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (n == LAT || n == WAKE + LAT - 1)
            check("R8 upper held off", expect_out(0, 0, 1, 0, 0, 19'h00007, 0));
         if (n == WAKE + LAT)
            check("R8 upper back", expect_out(0, 0, 1, 0, 0, 19'h00007, 1));
      end

      // random word-mode accesses: R2 R3 R4 R9 R10
      for (int k = 0; k < 200; k++) begin
         logic cs_n, g_n;
         logic [ADDR_W-1:0] a;
         cs_n = ($urandom % 4) == 0;
         g_n  = ($urandom % 4) == 0;
         a    = ADDR_W'($urandom);
         access(cs_n ? "R3" : (g_n ? "R4" : "R2 R10"), cs_n, g_n, 1, 1'($urandom), 0, a);
      end

      // random byte-mode accesses: R5 R6 R9
      for (int k = 0; k < 200; k++) begin
         logic cs_n, g_n;
         logic [ADDR_W-1:0] a;
         cs_n = ($urandom % 5) == 0;
         g_n  = ($urandom % 5) == 0;
         a    = ADDR_W'($urandom);
         access((cs_n || g_n) ? "R9" : "R5 R6", cs_n, g_n, 0, 1'($urandom), 0, a);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule